// File: doc/BRIEF.md
# Discard-Reason Error Counter Bank

A source-routing bridge filter throws away explorer frames for several reasons. This block keeps a tally of four of those reasons in four 8-bit counters that saturate at FFH:

- a spanning-tree explorer whose outbound LAN/bridge pair is already present in its routing field;
- a last-LAN-ID mismatch, for either explorer type;
- a hop limit exceeded on an all-routes explorer;
- a hop limit exceeded on a spanning-tree explorer.

The filter logic that makes the discard decisions drives one pulse per reason. With each pulse it supplies a frame-type bit that tells the bank which explorer type was dropped.

Software reads the bank over a 16-bit register port as a fixed sequence of three accesses, with two counters packed into each data word. A counter returns to zero as soon as its word has been read. A discard that arrives in the same cycle as the read of its counter is kept, not lost. The position in the sequence is held inside the block and advances on each read strobe. It returns to the first access after the third access. A read strobe that carries the start flag always restarts the sequence at the first access.

Top module: `dr_discard_cnt_bank`

## Requirements
- R1: After a synchronous active-high reset, all four counters read as zero, the sequence position is the first access, and rd_data is 0000H.
- R2: The duplicate counter increments only when drop_dup pulses with frm_ste=1 (spanning-tree explorer). A drop_dup pulse with frm_ste=0 leaves that counter unchanged.
- R3: The LAN-ID-mismatch counter increments on every drop_lid pulse, whatever the value of frm_ste.
- R4: A drop_hop pulse increments the all-routes hop counter when frm_ste=0 and the spanning-tree hop counter when frm_ste=1. The other hop counter is left unchanged.
- R5: Each counter stops at FFH and stays there on further events until it is read.
- R6: rd_data is updated on the clock edge that samples rd_stb and holds its value while rd_stb is low. Access 0 returns 0000H. Access 1 returns the duplicate count in bits 15–8 and the LAN-ID-mismatch count in bits 7–0. Access 2 returns the all-routes hop count in bits 15–8 and the spanning-tree hop count in bits 7–0.
- R7: The two counters returned by an access are cleared on that access. Counters in other words keep their values.
- R8: If an event and the read of the same counter fall in one cycle, the read returns the old value and the counter then holds 1.
- R9: After access 2 the next strobe is treated as access 0, so the sequence wraps.
- R10: A strobe with rd_start=1 is treated as access 0 wherever the sequence stood. rd_start without rd_stb has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_ste | input | 1 | Type of the discarded frame: 1 spanning-tree explorer, 0 all-routes explorer |
| drop_dup | input | 1 | Pulse: frame dropped because its outbound LAN/bridge pair was already in the routing field |
| drop_lid | input | 1 | Pulse: frame dropped because of a last-LAN-ID mismatch |
| drop_hop | input | 1 | Pulse: frame dropped because its hop limit was exceeded |
| rd_stb | input | 1 | Register read strobe, one access per cycle |
| rd_start | input | 1 | With rd_stb, restart the read sequence at access 0 |
| rd_data | output | 16 | Registered read word of the latest access |

## Verification
The bench models the counters and the sequence position independently of the RTL. It checks four corner cases:

- **Saturation.** It drives well over 255 duplicate events. A counter that wraps would read back a small value instead of FFH.
- **Collision.** It pulses events in the same cycle as the read of their counter. A design that lets the clear win would lose the event, and one that lets the increment win would not clear.
- **Frame-type steering.** It sends duplicate drops tagged as all-routes frames, and hop drops of both types. Wrong steering would put counts in the wrong byte or count duplicates that should be ignored.
- **Sequencing.** It wraps the sequence past access 2 and restarts it mid-sequence with rd_start. A design with an off-by-one index or an ignored restart would return the wrong pair and clear the wrong counters.

// File: rtl/dr_pkg.sv
package dr_pkg;

  typedef enum logic [1:0] {
    SLOT_HDR = 2'd0,
    SLOT_LAN = 2'd1,
    SLOT_HOP = 2'd2
  } slot_e;

  localparam int NUM_CNT  = 4;
  localparam int CNT_DUP  = 0;
  localparam int CNT_LID  = 1;
  localparam int CNT_AHOP = 2;
  localparam int CNT_SHOP = 3;

  // Sequence order: header slot, LAN pair, hop pair, then back to header.
  function automatic slot_e next_slot(input slot_e s);
    case (s)
      SLOT_HDR: next_slot = SLOT_LAN;
      SLOT_LAN: next_slot = SLOT_HOP;
      default:  next_slot = SLOT_HDR;
    endcase
  endfunction

endpackage

// File: rtl/dr_event_decode.sv
module dr_event_decode
  import dr_pkg::*;
(
  input  logic               frm_ste,
  input  logic               drop_dup,
  input  logic               drop_lid,
  input  logic               drop_hop,
  output logic [NUM_CNT-1:0] inc
);

  always_comb begin
    inc           = '0;
    // Duplicate pairs are only meaningful for spanning-tree explorers.
    inc[CNT_DUP]  = drop_dup & frm_ste;
    // Mismatch counts both explorer kinds.
    inc[CNT_LID]  = drop_lid;
    // Hop-limit drops split by explorer kind.
    inc[CNT_AHOP] = drop_hop & ~frm_ste;
    inc[CNT_SHOP] = drop_hop & frm_ste;
  end

endmodule

// File: rtl/dr_sat_counter.sv
module dr_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Clear on read has priority, but a same-cycle event survives as 1.
  function automatic logic [CNT_W-1:0] cnt_next(
    input logic [CNT_W-1:0] cur,
    input logic             up,
    input logic             wipe
  );
    if (wipe)
      cnt_next = up ? CNT_W'(1) : '0;
    else if (up && cur != CNT_MAX)
      cnt_next = cur + CNT_W'(1);
    else
      cnt_next = cur;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_next(cnt, inc, clr);
  end

endmodule

// File: rtl/dr_read_seq.sv
module dr_read_seq
  import dr_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 2 * CNT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_stb,
  input  logic                     rd_start,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  output logic [NUM_CNT-1:0]       clr,
  output logic [1:0]               slot_now,
  output logic [DATA_W-1:0]        rd_data
);

  slot_e slot_q;
  slot_e cur_slot;

  function automatic logic [CNT_W-1:0] cnt_at(
    input logic [NUM_CNT*CNT_W-1:0] flat,
    input int                       idx
  );
    cnt_at = flat[idx*CNT_W +: CNT_W];
  endfunction

  function automatic logic [DATA_W-1:0] pick_word(
    input slot_e                    s,
    input logic [NUM_CNT*CNT_W-1:0] flat
  );
    case (s)
      SLOT_LAN: pick_word = {cnt_at(flat, CNT_DUP),  cnt_at(flat, CNT_LID)};
      SLOT_HOP: pick_word = {cnt_at(flat, CNT_AHOP), cnt_at(flat, CNT_SHOP)};
      default:  pick_word = '0;
    endcase
  endfunction

  always_comb cur_slot = rd_start ? SLOT_HDR : slot_q;

  always_comb begin
    clr = '0;
    if (rd_stb) begin
      case (cur_slot)
        SLOT_LAN: begin
          clr[CNT_DUP] = 1'b1;
          clr[CNT_LID] = 1'b1;
        end
        SLOT_HOP: begin
          clr[CNT_AHOP] = 1'b1;
          clr[CNT_SHOP] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= SLOT_HDR;
      rd_data <= '0;
    end else if (rd_stb) begin
      slot_q  <= next_slot(cur_slot);
      rd_data <= pick_word(cur_slot, cnt_flat);
    end
  end

  assign slot_now = slot_q;

endmodule

// File: rtl/dr_discard_cnt_bank.sv
module dr_discard_cnt_bank
  import dr_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int DATA_W = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_ste,
  input  logic              drop_dup,
  input  logic              drop_lid,
  input  logic              drop_hop,
  input  logic              rd_stb,
  input  logic              rd_start,
  output logic [DATA_W-1:0] rd_data
);

  logic [NUM_CNT-1:0]       inc_vec;
  logic [NUM_CNT-1:0]       clr_vec;
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic [1:0]               seq_slot;

  dr_event_decode u_dec (
    .frm_ste  (frm_ste),
    .drop_dup (drop_dup),
    .drop_lid (drop_lid),
    .drop_hop (drop_hop),
    .inc      (inc_vec)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    dr_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .inc (inc_vec[g]),
      .clr (clr_vec[g]),
      .cnt (cnt_flat[g*CNT_W +: CNT_W])
    );
  end

  dr_read_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .rd_stb   (rd_stb),
    .rd_start (rd_start),
    .cnt_flat (cnt_flat),
    .clr      (clr_vec),
    .slot_now (seq_slot),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/dr_discard_cnt_bank_chk.sv
module dr_discard_cnt_bank_chk #(
  parameter int CNT_W   = 8,
  parameter int NUM_CNT = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     frm_ste,
  input logic                     drop_dup,
  input logic                     rd_stb,
  input logic                     rd_start,
  input logic [2*CNT_W-1:0]       rd_data,
  input logic [NUM_CNT-1:0]       inc_vec,
  input logic [NUM_CNT-1:0]       clr_vec,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  input logic [1:0]               seq_slot
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_prop
    assert_sat_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (cnt_flat[g*CNT_W +: CNT_W] == MAXV && !clr_vec[g])
        |=> cnt_flat[g*CNT_W +: CNT_W] == MAXV);

    assert_read_clear_R7: assert property (@(posedge clk) disable iff (rst)
      (clr_vec[g] && !inc_vec[g]) |=> cnt_flat[g*CNT_W +: CNT_W] == '0);

    assert_collide_one_R8: assert property (@(posedge clk) disable iff (rst)
      (clr_vec[g] && inc_vec[g]) |=> cnt_flat[g*CNT_W +: CNT_W] == CNT_W'(1));
  end

  assert_dup_are_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (drop_dup && !frm_ste && !clr_vec[0]) |=> $stable(cnt_flat[CNT_W-1:0]));

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));

  assert_slot_range_R9: assert property (@(posedge clk) disable iff (rst)
    seq_slot != 2'd3);

  assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_start) |=> seq_slot == 2'd1);

endmodule

bind dr_discard_cnt_bank dr_discard_cnt_bank_chk #(.CNT_W(CNT_W), .NUM_CNT(4)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .frm_ste  (frm_ste),
  .drop_dup (drop_dup),
  .rd_stb   (rd_stb),
  .rd_start (rd_start),
  .rd_data  (rd_data),
  .inc_vec  (inc_vec),
  .clr_vec  (clr_vec),
  .cnt_flat (cnt_flat),
  .seq_slot (seq_slot)
);

// File: tb/sim_dr_discard_cnt_bank.sv
`timescale 1ns/1ps
module sim_dr_discard_cnt_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm_ste = 1'b0, drop_dup = 1'b0, drop_lid = 1'b0, drop_hop = 1'b0;
  logic        rd_stb = 1'b0, rd_start = 1'b0;
  logic [15:0] rd_data;

  int n_chk = 0, n_bad = 0;
  int m[4];
  int mi = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dr_discard_cnt_bank u0 (
    .clk(clk), .rst(rst), .frm_ste(frm_ste), .drop_dup(drop_dup),
    .drop_lid(drop_lid), .drop_hop(drop_hop), .rd_stb(rd_stb),
    .rd_start(rd_start), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // One clock of stimulus; model updated from the requirement text.
  task automatic step(input bit ste, input bit dup, input bit lid, input bit hop,
                      input bit stb, input bit start, input string tag);
    int cur;
    logic [15:0] exp;
    bit up[4];
    @(negedge clk);
    frm_ste = ste; drop_dup = dup; drop_lid = lid; drop_hop = hop;
    rd_stb = stb; rd_start = start;
    cur = start ? 0 : mi;
    exp = (cur == 1) ? {m[0][7:0], m[1][7:0]} :
          (cur == 2) ? {m[2][7:0], m[3][7:0]} : 16'h0000;
    @(posedge clk); #1;
    frm_ste = 0; drop_dup = 0; drop_lid = 0; drop_hop = 0; rd_stb = 0; rd_start = 0;
    up[0] = dup && ste;  up[1] = lid;
    up[2] = hop && !ste; up[3] = hop && ste;
    for (int k = 0; k < 4; k++) begin
      bit wiped;
      wiped = stb && ((cur == 1 && k < 2) || (cur == 2 && k >= 2));
      if (wiped) m[k] = up[k] ? 1 : 0;
      else if (up[k] && m[k] < 255) m[k] = m[k] + 1;
    end
    if (stb) begin
      mi = (cur == 2) ? 0 : cur + 1;
      chk(tag, rd_data, exp);
    end
  endtask

  task automatic ev(input bit ste, input bit dup, input bit lid, input bit hop);
    step(ste, dup, lid, hop, 0, 0, "event");
  endtask

  task automatic rd(input bit start, input string tag);
    step(0, 0, 0, 0, 1, start, tag);
  endtask

  task automatic t_reset;
    chk("R1 rd_data at reset", rd_data, 16'h0000);
    rd(0, "R1 access0 after reset");
    rd(0, "R1 lan pair zero");
    rd(0, "R1 hop pair zero");
  endtask

  task automatic t_dup_steer;
    ev(1, 1, 0, 0); ev(1, 1, 0, 0); ev(1, 1, 0, 0);
    ev(0, 1, 0, 0); ev(0, 1, 0, 0);       // all-routes dup: ignored
    rd(1, "R2 access0");
    rd(0, "R2 dup counts STE only (expect 03 in high byte)");
    chk("R2 dup byte", {8'h00, rd_data[15:8]}, 16'h0003);
  endtask

  task automatic t_lid_both;
    ev(0, 0, 1, 0); ev(1, 0, 1, 0); ev(0, 0, 1, 0); ev(1, 0, 1, 0);
    rd(1, "R3 access0");
    rd(0, "R3 mismatch both types");
    chk("R3 lid byte", {8'h00, rd_data[7:0]}, 16'h0004);
    rd(0, "R3 hop pair");
  endtask

  task automatic t_hop_split;
    ev(0, 0, 0, 1); ev(0, 0, 0, 1); ev(1, 0, 0, 1);
    rd(1, "R4 access0");
    rd(0, "R4 lan pair untouched");
    rd(0, "R4 hop split");
    chk("R4 hop word", rd_data, 16'h0201);
  endtask

  task automatic t_clear_wrap;
    ev(1, 1, 1, 1); ev(0, 0, 0, 1);
    rd(1, "R7 access0");
    rd(0, "R7 lan pair read");
    rd(0, "R7 hop pair kept while lan read");
    chk("R7 hop word before clear", rd_data, 16'h0101);
    rd(0, "R9 wrap to access0");
    chk("R9 wrap word", rd_data, 16'h0000);
    rd(0, "R7 lan pair cleared");
    chk("R7 lan cleared", rd_data, 16'h0000);
    rd(0, "R7 hop pair cleared");
    chk("R7 hop cleared", rd_data, 16'h0000);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 300; i++) ev(1, 1, 0, 1);
    rd(1, "R5 access0");
    rd(0, "R5 dup saturates");
    chk("R5 dup FF", {8'h00, rd_data[15:8]}, 16'h00FF);
    rd(0, "R5 ste hop saturates");
    chk("R5 hop FF", rd_data, 16'h00FF);
  endtask

  task automatic t_collide;
    ev(1, 1, 1, 0); ev(1, 1, 0, 0);
    rd(1, "R8 access0");
    step(1, 1, 1, 0, 1, 0, "R8 read with same-cycle events");
    chk("R8 old value returned", rd_data, 16'h0201);
    rd(0, "R8 hop pair");
    rd(0, "R8 access0 again");
    rd(0, "R8 survivors equal one");
    chk("R8 survivors", rd_data, 16'h0101);
  endtask

  task automatic t_restart_hold;
    logic [15:0] held;
    ev(0, 0, 1, 0);
    rd(1, "R10 access0");
    step(0, 0, 0, 0, 0, 1, "R10 start without strobe");   // no effect
    rd(0, "R10 lone start ignored, lan pair read");
    chk("R10 lan pair", rd_data, 16'h0001);
    rd(1, "R10 restart mid-sequence");
    chk("R10 restart gives access0", rd_data, 16'h0000);
    ev(0, 0, 1, 0);
    rd(0, "R10 then lan pair");
    held = rd_data;
    ev(0, 0, 1, 0); ev(1, 0, 0, 1);
    chk("R6 rd_data held without strobe", rd_data, held);
    rd(0, "R6 hop pair");
  endtask

  initial begin
    for (int k = 0; k < 4; k++) m[k] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_dup_steer();
    t_lid_both();
    t_hop_split();
    t_clear_wrap();
    t_saturate();
    t_collide();
    t_restart_hold();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule